// File: doc/BRIEF.md
# Programmable-Priority Interrupt Controller

This block gathers interrupt requests from a bank of internal sources and a bank of external lines, latches or tracks them as pending, gates them with per-source enable bits and picks one winner for the processor core. The core sees a single interrupt line, which is high whenever any enabled source is pending. It reads a vector register to learn the number of the winning source.

Sources are arranged in groups of eight. Each group has a priority register that holds eight 3-bit slot fields. Each field names one member of the group, and slot 0 ranks highest. Across groups, a lower group index wins. A member that no slot names ranks below every slotted source, and such members are ordered by ascending source number. A configuration field can name one source that beats every slot assignment.

External lines can each be set to edge or level sensing. Internal sources are level-sensitive. Software can force any source pending, and it acknowledges edge-latched requests by writing 1 to their bits. Registers are 32 bits wide and word-addressed. A source at position n in a bank uses bit (31 − n) of that bank's pending, enable and force registers.

Top module: `prio_intc`

## Requirements
- R1: After reset the vector register reads 0, the core interrupt is low, every enable and force bit is 0, the override field is 0, and every priority register holds the identity assignment (slot p names member p).
- R2: Internal source i has source number i+1 and external line j has source number N_INT+1+j. The vector register returns the winner's number in bits 6:0, or 0 when no source is both pending and enabled.
- R3: An enable bit of 1 lets a pending source take part in arbitration and drive the core interrupt. An enable bit of 0 keeps the source out while its pending bit still reads back set.
- R4: A level-sensitive source's pending bit follows the sampled input, one clock after the input is sampled. Writing 1 to its pending bit has no effect while the input stays high.
- R5: An edge-sensitive external line latches a rising input into its pending bit. The bit stays set after the input falls and is cleared only by writing 1 to bit (31 − j) of the external pending register.
- R6: Writing 0 to a pending bit leaves it unchanged.
- R7: External sense register bit (15 − j) set to 1 selects edge sensing for line j, and set to 0 selects level sensing.
- R8: A set force bit makes its source pending exactly as if its input were high, and clearing it removes a level-sensitive request.
- R9: Slot p of a priority register sits at bit offset 29 − 3p for p < 4 and at 25 − 3p for p ≥ 4. Within a group, the member in the lowest-numbered slot wins, and a member named in several slots uses its best slot.
- R10: Among slotted sources, a lower group index wins. Internal source i is in group i/8 and external line j is in group N_INT/8 + j/8.
- R11: Members not named by any slot lose to every slotted source and are ordered among themselves by ascending source number.
- R12: When bits 30:24 of the configuration register hold the number of a pending, enabled source, that source wins regardless of slots.
- R13: The core interrupt is high exactly when the vector register is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_src | input | N_INT | Internal request inputs |
| ext_src | input | N_EXT | External request lines |
| reg_addr | input | AW | Word address of the register access |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| core_irq | output | 1 | Interrupt request to the core |

## Verification
The bench uses the default sizes: 32 internal sources and 8 external lines. That gives five priority groups, so the full 40-source map is exercised. With these sizes, ordering across groups (internal group 0 against group 1), the unslotted fallback and external source numbers 33 and above can all be tested directly. Edge latching, write-1 acknowledge, forcing and the override are each driven on specific sources, and the vector is predicted from the slot words the bench itself writes.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int REG_W  = 32;
    localparam int GRP    = 8;
    localparam int SLOT_W = 3;
    localparam int VEC_W  = 7;

    typedef enum logic [3:0] {
        A_CFG    = 4'd0,
        A_VEC    = 4'd1,
        A_IPEND  = 4'd2,
        A_IMASK  = 4'd3,
        A_IFORCE = 4'd4,
        A_EPEND  = 4'd5,
        A_EMASK  = 4'd6,
        A_EFORCE = 4'd7,
        A_ESENSE = 4'd8,
        A_PRIO0  = 4'd9
    } reg_sel_e;

    typedef struct packed {
        logic               slotted;
        logic [SLOT_W-1:0]  slot;
    } rank_t;

    function automatic int slot_lsb(input int p);
        return (p < 4) ? (20 + (3 - p) * 3) : (4 + (7 - p) * 3);
    endfunction

    function automatic logic [REG_W-1:0] identity_slots();
        logic [REG_W-1:0] w;
        w = '0;
        for (int p = 0; p < GRP; p++) begin
            w[slot_lsb(p) +: SLOT_W] = SLOT_W'(p);
        end
        return w;
    endfunction

endpackage

// File: rtl/intc_capture.sv
module intc_capture #(
    parameter int N = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    input  logic [N-1:0] force_on,
    input  logic [N-1:0] edge_mode,
    input  logic [N-1:0] ack,
    output logic [N-1:0] pend
);
    logic [N-1:0] eff;
    logic [N-1:0] eff_q;
    logic [N-1:0] pend_q;

    assign eff  = raw | force_on;
    assign pend = pend_q;

    for (genvar k = 0; k < N; k++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                eff_q[k]  <= 1'b0;
                pend_q[k] <= 1'b0;
            end else begin
                eff_q[k] <= eff[k];
                if (edge_mode[k]) begin
                    pend_q[k] <= (pend_q[k] & ~ack[k]) | (eff[k] & ~eff_q[k]);
                end else begin
                    pend_q[k] <= eff[k];
                end
            end
        end
    end
endmodule

// File: rtl/intc_slot_rank.sv
module intc_slot_rank
    import intc_pkg::*;
(
    input  logic [REG_W-1:0]       slots,
    output rank_t [GRP-1:0]        ranks
);
    always_comb begin
        ranks = '0;
        for (int p = GRP - 1; p >= 0; p--) begin
            for (int m = 0; m < GRP; m++) begin
                if (slots[slot_lsb(p) +: SLOT_W] == SLOT_W'(m)) begin
                    ranks[m].slotted = 1'b1;
                    ranks[m].slot    = SLOT_W'(p);
                end
            end
        end
    end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int NS = 40
) (
    input  logic [NS-1:0]     active,
    input  rank_t [NS-1:0]    ranks,
    input  logic [VEC_W-1:0]  hpi,
    output logic [VEC_W-1:0]  winner
);
    localparam int KEY_W = 1 + VEC_W;

    logic [KEY_W-1:0] best;
    logic [KEY_W-1:0] key;
    logic             found;
    logic             hpi_hit;

    always_comb begin
        best   = '1;
        found  = 1'b0;
        winner = '0;
        key    = '0;
        for (int s = 0; s < NS; s++) begin
            if (ranks[s].slotted) begin
                key = {1'b0, 4'(s / GRP), ranks[s].slot};
            end else begin
                key = {1'b1, VEC_W'(s)};
            end
            if (active[s] && (!found || key < best)) begin
                best   = key;
                found  = 1'b1;
                winner = VEC_W'(s + 1);
            end
        end
        hpi_hit = 1'b0;
        for (int s = 0; s < NS; s++) begin
            if (hpi == VEC_W'(s + 1) && active[s]) begin
                hpi_hit = 1'b1;
            end
        end
        if (hpi_hit) begin
            winner = hpi;
        end
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import intc_pkg::*;
#(
    parameter int N_INT = 32,
    parameter int N_EXT = 8,
    parameter int AW    = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_INT-1:0]   int_src,
    input  logic [N_EXT-1:0]   ext_src,
    input  logic [AW-1:0]      reg_addr,
    input  logic               reg_we,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               core_irq
);
    localparam int NS = N_INT + N_EXT;
    localparam int NG = NS / GRP;

    logic [NS-1:0]       mask_q;
    logic [NS-1:0]       force_q;
    logic [N_EXT-1:0]    sense_q;
    logic [VEC_W-1:0]    hpi_q;
    logic [REG_W-1:0]    prio_q [NG];

    logic [NS-1:0]       ack;
    logic [NS-1:0]       edge_mode;
    logic [NS-1:0]       pend;
    logic [NS-1:0]       active;
    rank_t [NS-1:0]      rank_all;
    logic [VEC_W-1:0]    vec;

    logic [3:0] sel;
    assign sel = 4'(reg_addr);

    always_comb begin
        ack = '0;
        if (reg_we && sel == A_IPEND) begin
            for (int i = 0; i < N_INT; i++) ack[i] = reg_wdata[REG_W-1-i];
        end
        if (reg_we && sel == A_EPEND) begin
            for (int j = 0; j < N_EXT; j++) ack[N_INT+j] = reg_wdata[REG_W-1-j];
        end
    end

    always_comb begin
        edge_mode = '0;
        for (int j = 0; j < N_EXT; j++) edge_mode[N_INT+j] = sense_q[j];
    end

    intc_capture #(.N(NS)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .raw       ({ext_src, int_src}),
        .force_on  (force_q),
        .edge_mode (edge_mode),
        .ack       (ack),
        .pend      (pend)
    );

    for (genvar g = 0; g < NG; g++) begin : g_grp
        intc_slot_rank u_rank (
            .slots (prio_q[g]),
            .ranks (rank_all[g*GRP +: GRP])
        );
    end

    assign active = pend & mask_q;

    intc_arbiter #(.NS(NS)) u_arb (
        .active (active),
        .ranks  (rank_all),
        .hpi    (hpi_q),
        .winner (vec)
    );

    assign core_irq = |active;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            force_q <= '0;
            sense_q <= '0;
            hpi_q   <= '0;
            for (int g = 0; g < NG; g++) prio_q[g] <= identity_slots();
        end else if (reg_we) begin
            case (sel)
                A_CFG:    hpi_q <= reg_wdata[30:24];
                A_IMASK:  for (int i = 0; i < N_INT; i++) mask_q[i] <= reg_wdata[REG_W-1-i];
                A_IFORCE: for (int i = 0; i < N_INT; i++) force_q[i] <= reg_wdata[REG_W-1-i];
                A_EMASK:  for (int j = 0; j < N_EXT; j++) mask_q[N_INT+j] <= reg_wdata[REG_W-1-j];
                A_EFORCE: for (int j = 0; j < N_EXT; j++) force_q[N_INT+j] <= reg_wdata[REG_W-1-j];
                A_ESENSE: for (int j = 0; j < N_EXT; j++) sense_q[j] <= reg_wdata[15-j];
                default: begin
                    for (int g = 0; g < NG; g++) begin
                        if (sel == 4'(int'(A_PRIO0) + g)) prio_q[g] <= reg_wdata;
                    end
                end
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            A_CFG:    reg_rdata[30:24] = hpi_q;
            A_VEC:    reg_rdata[VEC_W-1:0] = vec;
            A_IPEND:  for (int i = 0; i < N_INT; i++) reg_rdata[REG_W-1-i] = pend[i];
            A_IMASK:  for (int i = 0; i < N_INT; i++) reg_rdata[REG_W-1-i] = mask_q[i];
            A_IFORCE: for (int i = 0; i < N_INT; i++) reg_rdata[REG_W-1-i] = force_q[i];
            A_EPEND:  for (int j = 0; j < N_EXT; j++) reg_rdata[REG_W-1-j] = pend[N_INT+j];
            A_EMASK:  for (int j = 0; j < N_EXT; j++) reg_rdata[REG_W-1-j] = mask_q[N_INT+j];
            A_EFORCE: for (int j = 0; j < N_EXT; j++) reg_rdata[REG_W-1-j] = force_q[N_INT+j];
            A_ESENSE: for (int j = 0; j < N_EXT; j++) reg_rdata[15-j] = sense_q[j];
            default: begin
                for (int g = 0; g < NG; g++) begin
                    if (sel == 4'(int'(A_PRIO0) + g)) reg_rdata = prio_q[g];
                end
            end
        endcase
    end
endmodule

// File: rtl/intc_checker.sv
module intc_checker
    import intc_pkg::*;
#(
    parameter int NS = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              core_irq,
    input logic [VEC_W-1:0]  vec,
    input logic [VEC_W-1:0]  hpi,
    input logic [NS-1:0]     raw,
    input logic [NS-1:0]     force_on,
    input logic [NS-1:0]     edge_mode,
    input logic [NS-1:0]     ack,
    input logic [NS-1:0]     pend,
    input logic [NS-1:0]     mask
);
    // R13: interrupt line agrees with the vector
    p_irq_vec_r13: assert property (@(posedge clk) disable iff (rst)
        core_irq == (vec != '0));

    // R3: a reported winner is pending and enabled
    p_vec_enabled_r3: assert property (@(posedge clk) disable iff (rst)
        (vec != '0) |-> (pend[vec - 1'b1] && mask[vec - 1'b1]));

    // R12: an active override source is always the winner
    p_hpi_win_r12: assert property (@(posedge clk) disable iff (rst)
        (hpi != '0 && int'(hpi) <= NS && pend[hpi - 1'b1] && mask[hpi - 1'b1]) |-> (vec == hpi));

    for (genvar s = 0; s < NS; s++) begin : g_src
        // R4: level mode pending tracks the previous input
        p_level_follow_r4: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(edge_mode[s])) |-> (pend[s] == $past(raw[s] | force_on[s])));

        // R5: edge mode pending is held until acknowledged
        p_edge_hold_r5: assert property (@(posedge clk) disable iff (rst)
            (pend[s] && edge_mode[s] && !ack[s]) |=> pend[s]);
    end
endmodule

bind prio_intc intc_checker #(.NS(N_INT + N_EXT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .core_irq  (core_irq),
    .vec       (vec),
    .hpi       (hpi_q),
    .raw       ({ext_src, int_src}),
    .force_on  (force_q),
    .edge_mode (edge_mode),
    .ack       (ack),
    .pend      (pend),
    .mask      (mask_q)
);

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
    localparam int N_INT = 32;
    localparam int N_EXT = 8;

    localparam logic [3:0] R_CFG = 0, R_VEC = 1, R_IPEND = 2, R_IMASK = 3, R_IFORCE = 4,
                           R_EPEND = 5, R_EMASK = 6, R_ESENSE = 8, R_PRIO0 = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N_INT-1:0] int_src = '0;
    logic [N_EXT-1:0] ext_src = '0;
    logic [3:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        core_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    prio_intc #(.N_INT(N_INT), .N_EXT(N_EXT), .AW(4)) u_prio_intc (
        .clk(clk), .rst(rst), .int_src(int_src), .ext_src(ext_src),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .core_irq(core_irq)
    );

    function automatic logic [31:0] place(input int p, input int m);
        int off;
        off = (p < 4) ? (29 - 3 * p) : (25 - 3 * p);
        return 32'(m) << off;
    endfunction

    function automatic logic [31:0] ident();
        logic [31:0] w = '0;
        for (int p = 0; p < 8; p++) w |= place(p, p);
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(R_VEC, d);    check("R1 vector", d, 0);
        check("R1 irq", 32'(core_irq), 0);
        rd(R_IMASK, d);  check("R1 mask", d, 0);
        rd(R_IFORCE, d); check("R1 force", d, 0);
        rd(R_CFG, d);    check("R1 cfg", d, 0);
        rd(R_PRIO0, d);  check("R1 prio0 identity", d, ident());
        rd(R_PRIO0 + 4, d); check("R1 prio4 identity", d, ident());
    endtask

    task automatic t_mask_level();
        logic [31:0] d;
        int_src[3] = 1'b1; tick();
        rd(R_IPEND, d); check("R4 level pending", d, 32'h1 << 28);
        rd(R_VEC, d);   check("R3 disabled vector", d, 0);
        check("R3 disabled irq", 32'(core_irq), 0);
        wr(R_IMASK, 32'h1 << 28);
        rd(R_VEC, d);   check("R2 internal number", d, 4);
        check("R13 irq high", 32'(core_irq), 1);
        wr(R_IPEND, 32'h1 << 28); tick();
        rd(R_IPEND, d); check("R4 ack ignored while held", d, 32'h1 << 28);
        int_src[3] = 1'b0; tick();
        rd(R_IPEND, d); check("R4 level released", d, 0);
        check("R13 irq low", 32'(core_irq), 0);
        wr(R_IMASK, 0);
    endtask

    task automatic t_slots();
        logic [31:0] d;
        wr(R_IMASK, 32'hFFFF_0000);
        int_src[5] = 1'b1; int_src[2] = 1'b1; tick();
        rd(R_VEC, d); check("R9 identity slot order", d, 3);
        wr(R_PRIO0, place(0, 5) | place(1, 2) | place(2, 2));
        rd(R_VEC, d); check("R9 reprogrammed slot0", d, 6);
        wr(R_PRIO0, place(0, 2) | place(1, 1) | place(2, 5) | place(3, 2)
                    | place(4, 5) | place(5, 1) | place(6, 1) | place(7, 1));
        rd(R_VEC, d); check("R9 best slot of repeated member", d, 3);
        wr(R_PRIO0, ident());
        int_src[5] = 1'b0; int_src[9] = 1'b1; tick();
        rd(R_VEC, d); check("R10 lower group wins", d, 3);
        wr(R_PRIO0, 32'h0);
        int_src[2] = 1'b0; int_src[3] = 1'b1; int_src[6] = 1'b1; tick();
        rd(R_VEC, d); check("R11 slotted beats unslotted", d, 10);
        int_src[9] = 1'b0; tick();
        rd(R_VEC, d); check("R11 ascending unslotted", d, 4);
        wr(R_CFG, 32'd7 << 24);
        rd(R_VEC, d); check("R12 override wins", d, 7);
        wr(R_CFG, 32'd20 << 24);
        rd(R_VEC, d); check("R12 idle override ignored", d, 4);
        wr(R_CFG, 0); wr(R_PRIO0, ident());
        int_src = '0; tick();
        wr(R_IMASK, 0);
        rd(R_VEC, d); check("R2 idle vector", d, 0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr(R_ESENSE, 32'h1 << 15);
        wr(R_EMASK, 32'hC000_0000);
        ext_src[0] = 1'b1; tick();
        ext_src[0] = 1'b0; tick();
        rd(R_EPEND, d); check("R5 edge latched", d, 32'h8000_0000);
        rd(R_VEC, d);   check("R2 external number", d, 33);
        wr(R_EPEND, 0); tick();
        rd(R_EPEND, d); check("R6 write zero keeps", d, 32'h8000_0000);
        wr(R_EPEND, 32'h8000_0000); tick();
        rd(R_EPEND, d); check("R5 write one clears", d, 0);
        ext_src[1] = 1'b1; tick();
        wr(R_EPEND, 32'h4000_0000); tick();
        rd(R_EPEND, d); check("R7 line1 level held", d, 32'h4000_0000);
        rd(R_VEC, d);   check("R7 line1 number", d, 34);
        ext_src[1] = 1'b0; tick();
        rd(R_EPEND, d); check("R7 line1 level released", d, 0);
        rd(R_ESENSE, d); check("R7 sense readback", d, 32'h1 << 15);
        wr(R_EMASK, 0); wr(R_ESENSE, 0);
    endtask

    task automatic t_force();
        logic [31:0] d;
        wr(R_IMASK, 32'h1 << 27);
        wr(R_IFORCE, 32'h1 << 27); tick();
        rd(R_IPEND, d); check("R8 forced pending", d, 32'h1 << 27);
        rd(R_VEC, d);   check("R8 forced vector", d, 5);
        wr(R_IFORCE, 0); tick();
        rd(R_IPEND, d); check("R8 force removed", d, 0);
        check("R8 irq low", 32'(core_irq), 0);
        wr(R_IMASK, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();
        t_reset();
        t_mask_level();
        t_slots();
        t_edge();
        t_force();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule